// File: doc/BRIEF.md
# Port Address Decoder with Switch Input and LED Output Ports

This block sits next to a small 8-bit processor and watches its bus: the 16-bit address, the I/O-versus-memory indicator, and the active-low read and write strobes. From these signals it forms four active-low qualified strobes. Two are I/O read and write, used when the indicator is high. The other two are memory read and write, used when the indicator is low.

The block serves two ports. The input port returns the state of eight active-low switches to the processor. The output port holds a byte that drives eight active-low LEDs. A port is selected only when its address decode matches and the matching qualified strobe is active at the same time.

A parameter chooses how the ports are decoded. In port-space mode the block compares only the low address byte and uses the I/O strobes. In memory-space mode it compares all 16 address bits and uses the memory strobes. Both port addresses are parameters. The bidirectional data bus is split into an input, an output and an output enable, so that the pad ring can build the tri-state buffer.

Top module: `iodec_top`

## Requirements
- R1: `ior_n` is 0 exactly when `rd_n` is 0 and `io_m` is 1. `iow_n` is 0 exactly when `wr_n` is 0 and `io_m` is 1.
- R2: `memr_n` is 0 exactly when `rd_n` is 0 and `io_m` is 0. `memw_n` is 0 exactly when `wr_n` is 0 and `io_m` is 0.
- R3: `in_sel_n` is 0 only when two things hold at once: the address matches `IN_ADDR` (default 0x0080) and the read strobe of the selected mode is 0.
- R4: While `in_sel_n` is 0, `data_oe` is 1 and `data_out` equals `switch_n`, so a released switch reads 1 and a pressed switch reads 0. At all other times `data_oe` is 0.
- R5: `out_sel_n` is 0 only when the address matches `OUT_ADDR` (default 0x0081) and the write strobe of the selected mode is 0. `latch_en` is the NOR of `out_sel_n` and the write strobe, so it is 1 exactly while `out_sel_n` is 0.
- R6: On every rising clock edge where `latch_en` is 1, the output register loads `data_in`. When `latch_en` is 0, the register holds its value. `led_n` shows the register, and bit value 0 lights an LED.
- R7: While `rst_n` is 0, the output register is 0xFF, so every LED is dark.
- R8: With `MEM_MAPPED=1`, all 16 address bits must match and only the memory strobes select a port. I/O cycles at a matching address select nothing.
- R9: With `MEM_MAPPED=0`, address bits 15..8 are ignored, and memory cycles select nothing.
- R10: A read at the output port address, or a write at the input port address, selects neither port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 16 | Processor address bus |
| io_m | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| data_in | input | 8 | Data driven by the processor on writes |
| data_out | output | 8 | Data returned to the processor on reads |
| data_oe | output | 1 | Drive enable for the data bus pad |
| switch_n | input | 8 | Switch lines (0 = pressed) |
| ior_n | output | 1 | Qualified I/O read strobe |
| iow_n | output | 1 | Qualified I/O write strobe |
| memr_n | output | 1 | Qualified memory read strobe |
| memw_n | output | 1 | Qualified memory write strobe |
| in_sel_n | output | 1 | Input port select |
| out_sel_n | output | 1 | Output port select |
| latch_en | output | 1 | Active-high output register enable |
| led_n | output | 8 | LED drive (0 = lit) |

## Verification
Some rules are checked by assertions on every cycle. The strobe qualification must hold. Neither select may be active without its raw strobe. The bus enable must follow the input select. The output register must hold whenever its enable is low and must load the bus whenever it was high.

Other behaviour can only be shown by the bench's scenarios. These are the exact address comparison in each mode, the fact that the upper address byte is ignored in port-space mode, the rejection of reads and writes aimed at the wrong port, and the value the register holds after reset.

// File: rtl/iodec_pkg.sv
package iodec_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int PORT_W = 8;

    typedef struct packed {
        logic [DATA_W-1:0] leds;
    } out_state_t;

    localparam logic [DATA_W-1:0] LEDS_DARK = '1;
endpackage

// File: rtl/iodec_strobes.sv
module iodec_strobes (
    input  logic io_m,
    input  logic rd_n,
    input  logic wr_n,
    output logic ior_n,
    output logic iow_n,
    output logic memr_n,
    output logic memw_n
);
    always_comb begin
        ior_n  = ~(io_m & ~rd_n);
        iow_n  = ~(io_m & ~wr_n);
        memr_n = ~(~io_m & ~rd_n);
        memw_n = ~(~io_m & ~wr_n);
    end
endmodule

// File: rtl/iodec_match.sv
module iodec_match
    import iodec_pkg::*;
#(
    parameter bit                MEM_MAPPED = 1'b0,
    parameter logic [ADDR_W-1:0] MATCH_ADDR = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    generate
        if (MEM_MAPPED) begin : g_full
            assign hit = (addr == MATCH_ADDR);
        end else begin : g_port
            localparam logic [PORT_W-1:0] PORT_NUM = MATCH_ADDR[PORT_W-1:0];
            assign hit = (addr[PORT_W-1:0] == PORT_NUM);
        end
    endgenerate
endmodule

// File: rtl/iodec_out_reg.sv
module iodec_out_reg
    import iodec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);
    out_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d.leds = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.leds <= LEDS_DARK;
        end else begin
            state_q <= state_d;
        end
    end

    assign q = state_q.leds;

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q)); // R6
    AST_LOAD_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(din))); // R6
endmodule

// File: rtl/iodec_top.sv
module iodec_top
    import iodec_pkg::*;
#(
    parameter bit                MEM_MAPPED = 1'b0,
    parameter logic [ADDR_W-1:0] IN_ADDR    = 16'h0080,
    parameter logic [ADDR_W-1:0] OUT_ADDR   = 16'h0081
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              io_m,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    input  logic [DATA_W-1:0] switch_n,
    output logic              ior_n,
    output logic              iow_n,
    output logic              memr_n,
    output logic              memw_n,
    output logic              in_sel_n,
    output logic              out_sel_n,
    output logic              latch_en,
    output logic [DATA_W-1:0] led_n
);
    logic in_hit, out_hit;
    logic rd_strobe_n, wr_strobe_n;

    iodec_strobes u_strobes (
        .io_m   (io_m),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .ior_n  (ior_n),
        .iow_n  (iow_n),
        .memr_n (memr_n),
        .memw_n (memw_n)
    );

    iodec_match #(.MEM_MAPPED(MEM_MAPPED), .MATCH_ADDR(IN_ADDR)) u_in_match (
        .addr (addr),
        .hit  (in_hit)
    );

    iodec_match #(.MEM_MAPPED(MEM_MAPPED), .MATCH_ADDR(OUT_ADDR)) u_out_match (
        .addr (addr),
        .hit  (out_hit)
    );

    generate
        if (MEM_MAPPED) begin : g_mem_strobes
            assign rd_strobe_n = memr_n;
            assign wr_strobe_n = memw_n;
        end else begin : g_io_strobes
            assign rd_strobe_n = ior_n;
            assign wr_strobe_n = iow_n;
        end
    endgenerate

    always_comb begin
        in_sel_n  = ~(in_hit & ~rd_strobe_n);
        out_sel_n = ~(out_hit & ~wr_strobe_n);
        latch_en  = ~(out_sel_n | wr_strobe_n);
        data_oe   = ~in_sel_n;
        data_out  = switch_n;
    end

    iodec_out_reg u_out_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (latch_en),
        .din   (data_in),
        .q     (led_n)
    );

    AST_IOR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        !ior_n |-> (io_m && !rd_n)); // R1
    AST_MEMW_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        !memw_n |-> (!io_m && !wr_n)); // R2
    AST_IN_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !in_sel_n |-> !rd_n); // R3
    AST_OUT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en |-> (!wr_n && !out_sel_n)); // R5
    AST_BUS_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (!in_sel_n && data_out == switch_n)); // R4
endmodule

// File: tb/iodec_top_tb_top.sv
module iodec_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [15:0] addr;
    logic io_m, rd_n, wr_n;
    logic [7:0] data_in, switch_n;
    logic [7:0] data_out, led_n;
    logic data_oe, ior_n, iow_n, memr_n, memw_n, in_sel_n, out_sel_n, latch_en;

    logic [7:0] m_data_out, m_led_n;
    logic m_oe, m_ior, m_iow, m_memr, m_memw, m_in, m_out, m_le;

    int errors = 0;
    int checks = 0;

    iodec_top dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe), .switch_n(switch_n),
        .ior_n(ior_n), .iow_n(iow_n), .memr_n(memr_n), .memw_n(memw_n),
        .in_sel_n(in_sel_n), .out_sel_n(out_sel_n), .latch_en(latch_en), .led_n(led_n)
    );

    iodec_top #(.MEM_MAPPED(1'b1), .IN_ADDR(16'h8000), .OUT_ADDR(16'h8001)) dut_mem_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n),
        .data_in(data_in), .data_out(m_data_out), .data_oe(m_oe), .switch_n(switch_n),
        .ior_n(m_ior), .iow_n(m_iow), .memr_n(m_memr), .memw_n(m_memw),
        .in_sel_n(m_in), .out_sel_n(m_out), .latch_en(m_le), .led_n(m_led_n)
    );

    task automatic check(input string tag, input string what, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] a, input logic io, input logic r, input logic w,
                         input logic [7:0] d);
        @(negedge clk);
        addr = a; io_m = io; rd_n = r; wr_n = w; data_in = d;
        #2;
    endtask

    // {addr, io_m, rd_n, wr_n, ior, iow, memr, memw, in_sel, out_sel, oe}
    localparam int NV = 9;
    localparam logic [25:0] VEC [NV] = '{
        {16'h8080, 3'b101, 7'b0111011},  // R1 R3 R4 I/O read of input port
        {16'h8181, 3'b110, 7'b1011100},  // R1 R5 I/O write of output port
        {16'h0080, 3'b001, 7'b1101110},  // R2 R9 memory read ignored in port mode
        {16'h0081, 3'b010, 7'b1110110},  // R2 R9 memory write ignored
        {16'h8282, 3'b101, 7'b0111110},  // R3 unmatched port
        {16'h8080, 3'b111, 7'b1111110},  // R3 no strobe
        {16'h8181, 3'b101, 7'b0111110},  // R10 read at output port
        {16'h8080, 3'b110, 7'b1011110},  // R10 write at input port
        {16'hFF80, 3'b101, 7'b0111011}   // R9 upper byte ignored
    };

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        addr = 16'h0; io_m = 1'b0; rd_n = 1'b1; wr_n = 1'b1; data_in = 8'h00;
        switch_n = 8'b1111_1011;
        repeat (3) @(posedge clk);
        #2;
        check("R7", "led during reset", {8'h0, led_n}, 16'h00FF);
        check("R7", "mem led during reset", {8'h0, m_led_n}, 16'h00FF);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][25:10], VEC[i][9], VEC[i][8], VEC[i][7], 8'h00);
            check("R1", "ior_n", {15'h0, ior_n}, {15'h0, VEC[i][6]});
            check("R1", "iow_n", {15'h0, iow_n}, {15'h0, VEC[i][5]});
            check("R2", "memr_n", {15'h0, memr_n}, {15'h0, VEC[i][4]});
            check("R2", "memw_n", {15'h0, memw_n}, {15'h0, VEC[i][3]});
            check("R3", "in_sel_n", {15'h0, in_sel_n}, {15'h0, VEC[i][2]});
            check("R5", "out_sel_n", {15'h0, out_sel_n}, {15'h0, VEC[i][1]});
            check("R5", "latch_en", {15'h0, latch_en}, {15'h0, ~VEC[i][1]});
            check("R4", "data_oe", {15'h0, data_oe}, {15'h0, VEC[i][0]});
            if (VEC[i][0]) check("R4", "switch data", {8'h0, data_out}, {8'h0, switch_n});
        end

        // write 5Ah to output port in port mode
        drive(16'h8181, 1'b1, 1'b1, 1'b0, 8'h5A);
        @(posedge clk); #2;
        check("R6", "led after write", {8'h0, led_n}, 16'h005A);
        drive(16'h8181, 1'b1, 1'b1, 1'b1, 8'h33);
        @(posedge clk); #2;
        check("R6", "led holds", {8'h0, led_n}, 16'h005A);
        drive(16'h0081, 1'b0, 1'b1, 1'b0, 8'h11);
        @(posedge clk); #2;
        check("R9", "memory write no load", {8'h0, led_n}, 16'h005A);
        drive(16'h8080, 1'b1, 1'b1, 1'b0, 8'h22);
        @(posedge clk); #2;
        check("R10", "write at input port no load", {8'h0, led_n}, 16'h005A);
        switch_n = 8'h0F;
        drive(16'h8080, 1'b1, 1'b0, 1'b1, 8'h00);
        check("R4", "pressed switches read 0", {8'h0, data_out}, 16'h000F);

        // memory-mapped instance
        drive(16'h8000, 1'b0, 1'b0, 1'b1, 8'h00);
        check("R8", "mem read selects input", {15'h0, m_in}, 16'h0000);
        check("R8", "mem read oe", {15'h0, m_oe}, 16'h0001);
        drive(16'h0000, 1'b0, 1'b0, 1'b1, 8'h00);
        check("R8", "upper bits decoded", {15'h0, m_in}, 16'h0001);
        drive(16'h8000, 1'b1, 1'b0, 1'b1, 8'h00);
        check("R8", "io read ignored", {15'h0, m_in}, 16'h0001);
        drive(16'h8001, 1'b1, 1'b1, 1'b0, 8'h44);
        @(posedge clk); #2;
        check("R8", "io write no load", {8'h0, m_led_n}, 16'h00FF);
        drive(16'h8001, 1'b0, 1'b1, 1'b0, 8'hA5);
        check("R8", "mem write latch_en", {15'h0, m_le}, 16'h0001);
        @(posedge clk); #2;
        check("R8", "mem write loads", {8'h0, m_led_n}, 16'h00A5);
        drive(16'h0001, 1'b0, 1'b1, 1'b0, 8'h77);
        @(posedge clk); #2;
        check("R8", "short address no load", {8'h0, m_led_n}, 16'h00A5);

        // reset returns LEDs dark
        @(negedge clk); rst_n = 1'b0; #2;
        check("R7", "reset darkens leds", {8'h0, led_n}, 16'h00FF);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule